// File: doc/BRIEF.md
# Tiled 3x3 Mean Filter Engine

This block smooths one square tile of 8-bit pixels held in an external memory. After a `start` pulse it reads the whole tile into a local buffer through a request/ready read port. Read data comes back on a separate valid strobe, in request order. The engine starts no output work until every requested element has arrived. This acts as a hard barrier between a load phase and a compute phase.

In the compute phase the engine walks the tile in row-major order. For each pixel it forms the sum of its 3x3 neighbourhood, using only the staged buffer, and divides that sum by nine with round-to-nearest. It writes the result back to the address the pixel came from. Pixels on the tile edge have a window that would leave the tile, so they are written back unchanged. A one-cycle `done` pulse marks the end of the tile.

Tile width, tile height and pixel width are parameters. Width and height must be powers of two; the defaults are 16 x 16 and 8-bit. The address of pixel (row r, column c) is r*COLS + c.

Top module: `mf_tile_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_req`, `wr_req` and `done` are low until a `start` pulse is seen in the idle state.
- R2: After `start`, `rd_req` is raised and addresses 0 to 255 are requested in increasing (row-major) order. Each address is held until it is accepted (`rd_req` and `rd_ready` high at a clock edge). Every `rd_valid` beat during the load is stored at the next buffer position in request order.
- R3: `wr_req` is never raised before all 256 read data beats of the current tile have been received, and `rd_req` and `wr_req` are never high together.
- R4: For an interior pixel (row 1..14 and column 1..14), the value written is floor((S + 4) / 9). S is the 12-bit sum of the nine buffered pixels in rows r-1..r+1 and columns c-1..c+1.
- R5: For a border pixel (row 0, row 15, column 0 or column 15), the value written equals the value loaded from that address.
- R6: Writes go to addresses 0 to 255 in increasing order, one per accepted cycle (`wr_req` and `wr_ready` high). `wr_addr` and `wr_data` are held while `wr_ready` is low.
- R7: `done` is high for exactly one cycle, in the cycle right after the last write is accepted. It pulses once per tile.
- R8: A `start` pulse while a tile is being loaded or computed is ignored: no extra reads, writes or `done` pulse follow.
- R9: `rd_valid` beats that arrive while the engine is idle are ignored and do not disturb the next tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin processing one tile (honoured only when idle) |
| done | output | 1 | One-cycle pulse after the last write is accepted |
| rd_req | output | 1 | Read request |
| rd_addr | output | 8 | Read address, row*COLS + column |
| rd_ready | input | 1 | Memory accepts the read request this cycle |
| rd_valid | input | 1 | Read data beat present |
| rd_data | input | 8 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 8 | Write address, row*COLS + column |
| wr_data | output | 8 | Filtered pixel |
| wr_ready | input | 1 | Memory accepts the write this cycle |

## Verification
The embedded assertions assume that the memory returns exactly one `rd_valid` beat for each accepted read, in request order, and never more beats than requests. They also assume that `start` and the ready inputs are known values. The bench memory model presents each beat in the cycle after its request is accepted, and only for accepted requests, with stalls on both ready lines. The one exception is a deliberate burst of `rd_valid` beats while the engine is idle. That burst checks that such beats are discarded; it stays within the assumptions because the barrier counter only counts beats during the load phase.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CALC = 2'd2,
    ST_FIN  = 2'd3
  } mf_state_e;

  localparam int WIN_TAPS = 9;
endpackage

// File: rtl/mf_tile_buf.sv
module mf_tile_buf #(
  parameter int COLS  = 16,
  parameter int ROWS  = 16,
  parameter int PIX_W = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int CLW  = $clog2(COLS),
  localparam int AW   = RW + CLW,
  localparam int N    = ROWS * COLS
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [AW-1:0]           widx_i,
  input  logic [PIX_W-1:0]        wpix_i,
  input  logic [AW-1:0]           ctr_i,
  output logic [8:0][PIX_W-1:0]   win_o,
  output logic                    edge_o
);
  logic [PIX_W-1:0] store [N];
  logic [RW-1:0]    row;
  logic [CLW-1:0]   col;

  always_ff @(posedge clk) begin
    if (we_i) begin
      store[widx_i] <= wpix_i;
    end
  end

  assign row    = ctr_i[AW-1 -: RW];
  assign col    = ctr_i[CLW-1:0];
  assign edge_o = (row == '0) || (row == RW'(ROWS - 1)) ||
                  (col == '0) || (col == CLW'(COLS - 1));

  for (genvar gi = 0; gi < 3; gi++) begin : g_row
    logic [RW-1:0] r_sel;
    if (gi == 0) begin : g_up
      assign r_sel = (row == '0) ? row : row - RW'(1);
    end else if (gi == 1) begin : g_mid
      assign r_sel = row;
    end else begin : g_dn
      assign r_sel = (row == RW'(ROWS - 1)) ? row : row + RW'(1);
    end
    for (genvar gj = 0; gj < 3; gj++) begin : g_col
      logic [CLW-1:0] c_sel;
      if (gj == 0) begin : g_lf
        assign c_sel = (col == '0) ? col : col - CLW'(1);
      end else if (gj == 1) begin : g_ce
        assign c_sel = col;
      end else begin : g_rt
        assign c_sel = (col == CLW'(COLS - 1)) ? col : col + CLW'(1);
      end
      assign win_o[gi*3 + gj] = store[{r_sel, c_sel}];
    end
  end
endmodule

// File: rtl/mf_window_avg.sv
module mf_window_avg #(
  parameter int PIX_W  = 8,
  localparam int SUM_W = PIX_W + 4
) (
  input  logic [8:0][PIX_W-1:0] win_i,
  input  logic                  edge_i,
  output logic [PIX_W-1:0]      pix_o
);
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] quot;

  always_comb begin
    sum = '0;
    for (int k = 0; k < mf_pkg::WIN_TAPS; k++) begin
      sum = sum + SUM_W'(win_i[k]);
    end
  end

  assign quot  = SUM_W'((sum + SUM_W'(4)) / SUM_W'(9));
  assign pix_o = edge_i ? win_i[4] : quot[PIX_W-1:0];

  always_comb begin
    assert_no_overflow_R4: assert (edge_i || quot[SUM_W-1:PIX_W] == '0)
      else $error("window mean exceeds pixel range");
  end
endmodule

// File: rtl/mf_seq.sv
module mf_seq
  import mf_pkg::*;
#(
  parameter int N  = 256,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_ready_i,
  input  logic          rd_valid_i,
  input  logic          wr_ready_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_widx_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o
);
  mf_state_e     state_q, state_d;
  logic [CW-1:0] req_cnt_q, req_cnt_d;
  logic [CW-1:0] rcv_cnt_q, rcv_cnt_d;
  logic [AW-1:0] out_cnt_q, out_cnt_d;
  logic          rcv_en;

  assign rd_req_o   = (state_q == ST_LOAD) && (req_cnt_q < CW'(N));
  assign rd_addr_o  = req_cnt_q[AW-1:0];
  assign rcv_en     = (state_q == ST_LOAD) && rd_valid_i && (rcv_cnt_q < CW'(N));
  assign buf_we_o   = rcv_en;
  assign buf_widx_o = rcv_cnt_q[AW-1:0];
  assign wr_req_o   = (state_q == ST_CALC);
  assign wr_addr_o  = out_cnt_q;
  assign done_o     = (state_q == ST_FIN);

  always_comb begin
    state_d   = state_q;
    req_cnt_d = req_cnt_q;
    rcv_cnt_d = rcv_cnt_q;
    out_cnt_d = out_cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_LOAD;
          req_cnt_d = '0;
          rcv_cnt_d = '0;
        end
      end
      ST_LOAD: begin
        if (rd_req_o && rd_ready_i) begin
          req_cnt_d = req_cnt_q + CW'(1);
        end
        if (rcv_en) begin
          rcv_cnt_d = rcv_cnt_q + CW'(1);
        end
        if (rcv_cnt_q == CW'(N)) begin
          state_d   = ST_CALC;
          out_cnt_d = '0;
        end
      end
      ST_CALC: begin
        if (wr_ready_i) begin
          if (out_cnt_q == AW'(N - 1)) begin
            state_d = ST_FIN;
          end else begin
            out_cnt_d = out_cnt_q + AW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_cnt_q <= '0;
      rcv_cnt_q <= '0;
      out_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      req_cnt_q <= req_cnt_d;
      rcv_cnt_q <= rcv_cnt_d;
      out_cnt_q <= out_cnt_d;
    end
  end

  assert_barrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (rcv_cnt_q == CW'(N)))
    else $error("write before tile fully loaded");

  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o))
    else $error("read and write requested together");

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)))
    else $error("read request dropped or moved while stalled");

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ready_i) |=> (wr_req_o && $stable(wr_addr_o)))
    else $error("write request dropped or moved while stalled");

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  assert_done_after_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_req_o && wr_ready_i))
    else $error("done not preceded by an accepted write");

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && $stable(rcv_cnt_q)))
    else $error("idle state disturbed without start");
endmodule

// File: rtl/mf_tile_engine.sv
module mf_tile_engine #(
  parameter int COLS  = 16,
  parameter int ROWS  = 16,
  parameter int PIX_W = 8,
  localparam int N    = COLS * ROWS,
  localparam int AW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ready,
  input  logic             rd_valid,
  input  logic [PIX_W-1:0] rd_data,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  input  logic             wr_ready
);
  logic [1:0]              rst_pipe;
  logic                    rst_n_sync;
  logic                    buf_we;
  logic [AW-1:0]           buf_widx;
  logic [8:0][PIX_W-1:0]   win;
  logic                    on_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[1];

  mf_seq #(.N(N)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start_i    (start),
    .rd_ready_i (rd_ready),
    .rd_valid_i (rd_valid),
    .wr_ready_i (wr_ready),
    .rd_req_o   (rd_req),
    .rd_addr_o  (rd_addr),
    .buf_we_o   (buf_we),
    .buf_widx_o (buf_widx),
    .wr_req_o   (wr_req),
    .wr_addr_o  (wr_addr),
    .done_o     (done)
  );

  mf_tile_buf #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_buf (
    .clk    (clk),
    .we_i   (buf_we),
    .widx_i (buf_widx),
    .wpix_i (rd_data),
    .ctr_i  (wr_addr),
    .win_o  (win),
    .edge_o (on_edge)
  );

  mf_window_avg #(.PIX_W(PIX_W)) u_avg (
    .win_i  (win),
    .edge_i (on_edge),
    .pix_o  (wr_data)
  );

  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_req && !wr_ready) |=> $stable(wr_data))
    else $error("write data changed while stalled");

  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_n_sync |-> !(rd_req || wr_req || done))
    else $error("activity during reset");
endmodule

// File: tb/sim_mf_tile_engine.sv
`timescale 1ns/1ps
module sim_mf_tile_engine;
  localparam int COLS = 16;
  localparam int ROWS = 16;
  localparam int PW   = 8;
  localparam int NPIX = COLS * ROWS;

  logic       clk = 1'b0;
  logic       rst_n, start, done;
  logic       rd_req, rd_ready, rd_valid, wr_req, wr_ready;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;

  always #4 clk = ~clk;

  mf_tile_engine #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  int img     [NPIX];
  int exp_pix [NPIX];
  int got     [NPIX];

  // {kind[23:20], seed[19:12], rd stall period[11:8], wr stall period[7:4], flags[3:0]}
  localparam logic [23:0] VEC [8] = '{
    {4'd0, 8'd77,  4'd0, 4'd0, 4'd0},
    {4'd1, 8'd0,   4'd0, 4'd0, 4'd0},
    {4'd2, 8'd5,   4'd3, 4'd0, 4'd0},
    {4'd2, 8'd91,  4'd0, 4'd2, 4'd0},
    {4'd3, 8'd0,   4'd4, 4'd3, 4'd0},
    {4'd4, 8'd0,   4'd0, 4'd2, 4'd1},
    {4'd0, 8'd0,   4'd5, 4'd5, 4'd0},
    {4'd2, 8'd200, 4'd3, 4'd5, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int gen_pix(input int kind, input int seed, input int r, input int c);
    case (kind)
      0: return seed;
      1: return (r * 16 + c) & 255;
      2: return ((r * 37 + c * 11 + seed * 3) ^ (r * c)) & 255;
      3: return ((r + c) & 1) ? 255 : 0;
      default: return 255;
    endcase
  endfunction

  task automatic run_tile(input int kind, input int seed, input int rdm, input int wrm,
                          input bit restart);
    int next_rd = 0, next_wr = 0, rcvd = 0, dones = 0, last_at = -10, cyc = 0;
    int rd_err = 0, wr_err = 0, done_err = 0, late_req = 0, rcvd_first = -1;
    bit pend = 1'b0;
    int pend_addr = 0;
    bit border;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        img[r*COLS + c] = gen_pix(kind, seed, r, c);
      end
    end
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int s = 0;
        if (r == 0 || c == 0 || r == ROWS-1 || c == COLS-1) begin
          exp_pix[r*COLS + c] = img[r*COLS + c];
        end else begin
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
              s += img[(r+dr)*COLS + c + dc];
          exp_pix[r*COLS + c] = (s + 4) / 9;
        end
        got[r*COLS + c] = -1;
      end
    end
    while (cyc < 6000) begin
      @(negedge clk);
      start    = (cyc == 0) || (restart && cyc == 300);
      rd_valid = pend;
      rd_data  = pend ? 8'(img[pend_addr]) : 8'h00;
      if (pend) rcvd++;
      pend     = 1'b0;
      rd_ready = (rdm == 0) || ((cyc % rdm) != 0);
      wr_ready = (wrm == 0) || (((cyc + 1) % wrm) != 0);
      if (rd_req && rd_ready) begin
        if (int'(rd_addr) != next_rd) rd_err++;
        next_rd++;
        pend = 1'b1;
        pend_addr = int'(rd_addr);
      end
      if (rd_req && dones > 0) late_req++;
      if (wr_req && rcvd_first < 0) rcvd_first = rcvd;
      if (wr_req && wr_ready) begin
        if (int'(wr_addr) != next_wr) wr_err++;
        got[wr_addr] = int'(wr_data);
        next_wr++;
        if (next_wr == NPIX) last_at = cyc;
      end
      if (done) begin
        dones++;
        if (cyc != last_at + 1) done_err++;
      end
      if (dones > 0 && cyc > last_at + 20) break;
      cyc++;
    end
    start = 1'b0;
    rd_valid = 1'b0;
    chk(rd_err == 0,        "R2 read address order", rd_err, 0);
    chk(next_rd == NPIX,    "R2 read count R8", next_rd, NPIX);
    chk(rcvd_first == NPIX, "R3 beats received before first write", rcvd_first, NPIX);
    chk(wr_err == 0,        "R6 write address order", wr_err, 0);
    chk(next_wr == NPIX,    "R6 write count R8", next_wr, NPIX);
    chk(dones == 1,         "R7 done pulses per tile R8", dones, 1);
    chk(done_err == 0,      "R7 done timing after last write", done_err, 0);
    chk(late_req == 0,      "R8 no reads after done", late_req, 0);
    for (int i = 0; i < NPIX; i++) begin
      border = (i / COLS == 0) || (i / COLS == ROWS-1) || (i % COLS == 0) || (i % COLS == COLS-1);
      chk(got[i] == exp_pix[i], border ? "R5 border pixel" : "R4 interior mean", got[i], exp_pix[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_ready = 1'b0; rd_valid = 1'b0;
    rd_data = 8'h00; wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !wr_req && !done, "R1 outputs in reset", {rd_req, wr_req, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!rd_req && !wr_req && !done, "R1 idle after release", {rd_req, wr_req, done}, 0);

    for (int v = 0; v < 8; v++) begin
      run_tile(int'(VEC[v][23:20]), int'(VEC[v][19:12]), int'(VEC[v][11:8]),
               int'(VEC[v][7:4]), VEC[v][0]);
      repeat (3) @(negedge clk);
    end

    // reset in the middle of a load
    @(negedge clk); start = 1'b1; rd_ready = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(rd_req == 1'b1, "R2 loading before mid-run reset", rd_req, 1);
    rst_n = 1'b0;
    #1;
    chk(!rd_req && !wr_req && !done, "R1 mid-run reset clears outputs", {rd_req, wr_req, done}, 0);
    @(negedge clk); rst_n = 1'b1; rd_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(!rd_req && !wr_req && !done, "R1 idle after mid-run reset", {rd_req, wr_req, done}, 0);

    // stray read beats while idle
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rd_valid = 1'b1;
      rd_data  = 8'hAA;
    end
    @(negedge clk);
    rd_valid = 1'b0;
    chk(!rd_req && !wr_req && !done, "R9 idle beats start nothing", {rd_req, wr_req, done}, 0);
    run_tile(1, 0, 2, 0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule